// File: doc/BRIEF.md
# Shared I2C Engine Ownership Arbiter

This block decides which agent drives a single shared I2C engine. Three parties compete for it. A hardware agent works on its own and always has priority. A firmware microcontroller can reserve the engine through a control-status field. Host software asks for the engine with a level request and gives it back with a done pulse. The engine itself is outside the block; the block sees it only as a busy level, which is high while a transaction is on the wire.

The arbiter reports a two-bit ownership status. It forwards software start commands to the engine as a one-cycle pulse. When a software start arrives while hardware holds the engine, a configuration input chooses whether that start is queued or thrown away. A software job that hardware preempts is started again once hardware lets go.

Top module: `i2c_own_arb`

## Requirements
- R1: `own_status_o` is 2'b00 when idle, 2'b01 when software owns the engine and 2'b10 when hardware owns it. It never shows 2'b11 and it is 2'b00 after reset.
- R2: Software is granted the engine (status 2'b01 after the next edge) when all of the following hold: the status is idle, `sw_req_i` is high, `eng_busy_i` is low, no hardware request is present, and the lock is not set.
- R3: While `ctrl_stat_i` equals the firmware-only code (default 2'b10), software is never granted the engine from idle or after a hardware release.
- R4: A hardware request wins over a software request from idle. It also preempts a software owner at the next edge on which `eng_busy_i` is low, and the status then becomes 2'b10.
- R5: The ownership status never changes on an edge where `eng_busy_i` was high.
- R6: Software ownership ends, returning to idle, on an edge where `sw_done_i` is high or `sw_req_i` is low and the engine is not busy. Hardware ownership ends when `hw_req_i` is low and the engine is not busy.
- R7: A software start (`sw_go_i`) seen while software owns the engine, with no preemption on the same edge, gives a one-cycle `eng_go_o` pulse in the following cycle.
- R8: With `no_queue_go_i` low, a software start seen while hardware owns the engine is held. On the first cycle after hardware releases to a requesting software owner, `eng_go_o` pulses and the status reads 2'b01.
- R9: A software start that is neither issued nor queued gives a one-cycle `go_drop_o` pulse instead. This covers a start with `no_queue_go_i` high during hardware ownership, and a start while the status is idle.
- R10: A software job that was started and not finished when hardware preempted it is started again, with `eng_go_o` pulsing, on the first cycle after hardware hands the engine back to software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_i | input | 1 | Hardware agent wants the engine (level) |
| sw_req_i | input | 1 | Software use request (level) |
| sw_done_i | input | 1 | Software release pulse |
| sw_go_i | input | 1 | Software start command (pulse) |
| no_queue_go_i | input | 1 | 1: drop a software start during hardware ownership; 0: queue it |
| ctrl_stat_i | input | CTRL_W | Access-control status; FW_ONLY code locks software out |
| eng_busy_i | input | 1 | Engine transaction in progress |
| own_status_o | output | 2 | Ownership status (R1 encoding) |
| eng_go_o | output | 1 | Start pulse to the engine on behalf of software |
| go_drop_o | output | 1 | Software start was rejected |

## Verification
The assertions assume that `sw_go_i` and `sw_done_i` are single-cycle pulses. They also assume that `eng_busy_i` only falls between transactions, so a low busy marks a legal hand-over point. The stimulus changes every input half a cycle away from the clock edge. It raises busy only around ownership changes, to show that those changes are held off. It never drives the reserved status code and never drives two software pulses on the same cycle.

// File: rtl/i2c_own_arb_pkg.sv
package i2c_own_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'b00,
    OWN_SW   = 2'b01,
    OWN_HW   = 2'b10
  } own_e;
endpackage

// File: rtl/i2c_own_fsm.sv
module i2c_own_fsm
  import i2c_own_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hw_req,
  input  logic sw_req,
  input  logic sw_done,
  input  logic locked,
  input  logic busy,
  output own_e cur,
  output own_e nxt
);
  always_comb begin
    nxt = cur;
    if (!busy) begin
      unique case (cur)
        OWN_IDLE: begin
          if (hw_req)                nxt = OWN_HW;
          else if (sw_req && !locked) nxt = OWN_SW;
        end
        OWN_SW: begin
          if (hw_req)                 nxt = OWN_HW;
          else if (sw_done || !sw_req) nxt = OWN_IDLE;
        end
        OWN_HW: begin
          if (!hw_req) nxt = (sw_req && !locked) ? OWN_SW : OWN_IDLE;
        end
        default: nxt = OWN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= OWN_IDLE;
    else     cur <= nxt;
  end

  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    cur != 2'b11);
  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(cur));
  a_r3_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (cur == OWN_IDLE && locked) |=> cur != OWN_SW);
  a_r4_preempt: assert property (@(posedge clk) disable iff (rst)
    (cur == OWN_SW && hw_req && !busy) |=> cur == OWN_HW);
endmodule

// File: rtl/i2c_go_ctrl.sv
module i2c_go_ctrl
  import i2c_own_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  own_e cur,
  input  own_e nxt,
  input  logic sw_go,
  input  logic sw_done,
  input  logic no_queue,
  output logic eng_go,
  output logic go_drop
);
  logic pending_q, active_q;
  logic issue, queue_go, preempt, hw_to_sw;

  assign preempt  = (cur == OWN_SW) && (nxt == OWN_HW);
  assign hw_to_sw = (cur == OWN_HW) && (nxt == OWN_SW);
  assign issue    = ((cur == OWN_SW) && (nxt == OWN_SW) && sw_go) ||
                    (hw_to_sw && (pending_q || sw_go));
  assign queue_go = sw_go && !no_queue && (nxt == OWN_HW);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      eng_go    <= 1'b0;
      go_drop   <= 1'b0;
    end else begin
      eng_go  <= issue;
      go_drop <= sw_go && !issue && !queue_go;
      if (nxt != OWN_HW) pending_q <= 1'b0;
      else if (queue_go || (preempt && active_q)) pending_q <= 1'b1;
      if (issue) active_q <= 1'b1;
      else if (nxt != OWN_SW || sw_done) active_q <= 1'b0;
    end
  end

  a_r7_go_needs_sw: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> cur == OWN_SW);
  a_r9_go_or_drop: assert property (@(posedge clk) disable iff (rst)
    !(eng_go && go_drop));
  a_r8_no_pending_idle: assert property (@(posedge clk) disable iff (rst)
    (cur == OWN_IDLE) |-> !pending_q);
endmodule

// File: rtl/i2c_own_arb.sv
module i2c_own_arb
  import i2c_own_arb_pkg::*;
#(
  parameter int              CTRL_W  = 2,
  parameter logic [CTRL_W-1:0] FW_ONLY = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_req_i,
  input  logic              sw_req_i,
  input  logic              sw_done_i,
  input  logic              sw_go_i,
  input  logic              no_queue_go_i,
  input  logic [CTRL_W-1:0] ctrl_stat_i,
  input  logic              eng_busy_i,
  output logic [1:0]        own_status_o,
  output logic              eng_go_o,
  output logic              go_drop_o
);
  own_e cur_own, nxt_own;
  logic locked;

  assign locked = (ctrl_stat_i == FW_ONLY);

  i2c_own_fsm u_fsm (
    .clk(clk), .rst(rst), .hw_req(hw_req_i), .sw_req(sw_req_i),
    .sw_done(sw_done_i), .locked(locked), .busy(eng_busy_i),
    .cur(cur_own), .nxt(nxt_own)
  );

  i2c_go_ctrl u_go (
    .clk(clk), .rst(rst), .cur(cur_own), .nxt(nxt_own), .sw_go(sw_go_i),
    .sw_done(sw_done_i), .no_queue(no_queue_go_i),
    .eng_go(eng_go_o), .go_drop(go_drop_o)
  );

  assign own_status_o = cur_own;

  a_r6_hw_release: assert property (@(posedge clk) disable iff (rst)
    (cur_own == OWN_HW && !hw_req_i && !eng_busy_i) |=> cur_own != OWN_HW);
endmodule

// File: tb/i2c_own_arb_tb_top.sv
module i2c_own_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst, hw, sw, done, go, noq, busy;
  logic [1:0] ctrl, st;
  logic ego, drop;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_own_arb dut_i (
    .clk(clk), .rst(rst), .hw_req_i(hw), .sw_req_i(sw), .sw_done_i(done),
    .sw_go_i(go), .no_queue_go_i(noq), .ctrl_stat_i(ctrl), .eng_busy_i(busy),
    .own_status_o(st), .eng_go_o(ego), .go_drop_o(drop)
  );

  // {hw, sw, done, go, noq, busy, ctrl[1:0], exp_st[1:0], exp_go, exp_drop, req}
  typedef struct packed {
    logic hw, sw, done, go, noq, busy;
    logic [1:0] ctrl, est;
    logic ego, edrop;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{0,1,0,0,0,0,2'b00,2'b01,0,0,8'd2},  // R2 grant
    '{0,1,0,1,0,0,2'b00,2'b01,1,0,8'd7},  // R7 go issued
    '{0,1,0,0,0,1,2'b00,2'b01,0,0,8'd5},  // R5 busy
    '{1,1,0,0,0,1,2'b00,2'b01,0,0,8'd5},  // R5 preempt held by busy
    '{1,1,0,0,0,0,2'b00,2'b10,0,0,8'd4},  // R4 preempt
    '{1,1,0,0,0,1,2'b00,2'b10,0,0,8'd4},
    '{0,1,0,0,0,0,2'b00,2'b01,1,0,8'd10}, // R10 restart
    '{0,0,1,0,0,0,2'b00,2'b00,0,0,8'd6},  // R6 release
    '{0,1,0,0,0,0,2'b10,2'b00,0,0,8'd3},  // R3 locked
    '{1,0,0,0,0,0,2'b00,2'b10,0,0,8'd4},
    '{1,1,0,1,1,0,2'b00,2'b10,0,1,8'd9},  // R9 dropped
    '{0,1,0,0,0,0,2'b00,2'b01,0,0,8'd8},  // R8 nothing queued
    '{1,1,0,0,0,0,2'b00,2'b10,0,0,8'd4},
    '{1,1,0,1,0,0,2'b00,2'b10,0,0,8'd8},  // R8 queued
    '{0,1,0,0,0,0,2'b00,2'b01,1,0,8'd8},  // R8 issued
    '{0,0,0,0,0,0,2'b00,2'b00,0,0,8'd6},
    '{0,0,0,1,0,0,2'b00,2'b00,0,1,8'd9},  // R9 idle go
    '{1,0,0,0,0,1,2'b00,2'b00,0,0,8'd5}   // R5 busy blocks hw
  };

  task automatic chk(input int req, input logic [1:0] es, input logic eg, input logic ed);
    checks++;
    if (st !== es || ego !== eg || drop !== ed) begin
      errors++;
      $display("FAIL R%0d: st=%b go=%b drop=%b expected st=%b go=%b drop=%b",
               req, st, ego, drop, es, eg, ed);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    {hw, sw, done, go, noq, busy} = '0;
    ctrl = 2'b00;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(1, 2'b00, 0, 0);  // R1 reset state
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {hw, sw, done, go, noq, busy} = {VT[i].hw, VT[i].sw, VT[i].done,
                                       VT[i].go, VT[i].noq, VT[i].busy};
      ctrl = VT[i].ctrl;
      @(posedge clk); #1;
      chk(int'(VT[i].req), VT[i].est, VT[i].ego, VT[i].edrop);
    end
    // R4 hw wins over simultaneous sw request from idle
    @(negedge clk) {hw, sw, done, go, noq, busy} = 6'b110000;
    @(posedge clk); #1; chk(4, 2'b10, 0, 0);
    // R3 lock blocks sw after hw release
    @(negedge clk) begin hw = 0; ctrl = 2'b10; end
    @(posedge clk); #1; chk(3, 2'b00, 0, 0);
    // R1 reset returns to idle from software ownership
    @(negedge clk) ctrl = 2'b00;
    @(posedge clk); #1; chk(2, 2'b01, 0, 0);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1; chk(1, 2'b00, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule